// File: doc/BRIEF.md
# Aliased Bank Open-Row Tracker

This block sits in front of the command issue stage of an eight-bank DDR2 memory controller and decides, for each access, which commands the memory must see. Banks are tracked in four slots. A slot is indexed by the two low bank-address bits, so two banks that differ only in the top bank-address bit share one slot. Because of this, at most four banks can ever be open at the same time.

An access arrives on a valid/ready request port with a bank, a row and a read/write flag. The slot for that access is looked up, and the access falls into one of three cases:

- **Row hit:** the slot is valid and holds the same bank and row. Only the column command is issued.
- **Empty slot:** the slot is not valid. An activate is issued, then the column command.
- **Conflict:** the slot holds a different row of the same bank, or any row of the partner bank. The open bank is precharged, then the requested bank is activated, then the column command is issued.

Commands leave one at a time on a valid/ready command port. A parameterised number of idle cycles is kept between precharge and activate, and between activate and column command. A precharge-all input empties every slot. Partner banks that are accessed in turn miss every time. This is correct, expected behaviour.

Top module: `bank_row_tracker`

## Requirements
- R1: After reset, req_ready is 1 and cmd_valid is 0. Every slot is empty, so the first access to any bank issues an activate followed by its column command.
- R2: When the slot indexed by bank bits [1:0] is valid and holds the same 3-bit bank and the same row, the only command issued is a column command. The column command is READ (cmd_op 0) or WRITE (cmd_op 1).
- R3: When the indexed slot is not valid, ACT (cmd_op 2) is issued with the request's bank and row on cmd_bank and cmd_row, then the column command. The slot then holds that bank and row.
- R4: When the indexed slot holds the same bank with a different row, three commands are issued in order: PRE (cmd_op 3) to that bank, ACT with the new row, then the column command.
- R5: When the indexed slot holds the partner bank (requested bank XOR 4), PRE goes to the open partner bank, then ACT to the requested bank, then the column command. Afterwards the requested bank is open and the partner bank is closed.
- R6: Slots are independent. Banks that differ in bits [1:0] stay open together, and an ACT is never issued to a slot that already holds an open bank.
- R7: Between the PRE handshake and the ACT handshake of one access, cmd_valid is low for at least MIN_GAP cycles. The same holds between ACT and the column command. When cmd_ready stays high, the gap is exactly MIN_GAP cycles.
- R8: While cmd_valid is high and cmd_ready is low, cmd_op, cmd_bank and cmd_row hold steady. req_ready is low from the cycle after an accepted request until its column command has been handed over.
- R9: A cycle with pre_all high while the block is idle empties every slot. No request is accepted in that cycle.
- R10: The column command carries the request's 3-bit bank, its row, and WRITE if the write flag was set, READ otherwise.
- R11: The first command of an accepted request is valid in the cycle right after acceptance. req_ready is high again in the cycle right after the column handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_bank | input | BANK_W | Requested bank address |
| req_row | input | ROW_W | Requested row address |
| req_write | input | 1 | 1 for write, 0 for read |
| pre_all | input | 1 | Close every tracked bank |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Command taken by the issue stage |
| cmd_op | output | 2 | 0 READ, 1 WRITE, 2 ACT, 3 PRE |
| cmd_bank | output | BANK_W | Bank the command targets |
| cmd_row | output | ROW_W | Row of the access (meaningful for ACT and column commands) |

## Verification
The assertions assume that pre_all is raised only while the block is idle, that is, with no access sequence in progress. They also assume that the command consumer may hold cmd_ready low for any length of time. The stimulus meets the first assumption by waiting until every expected command has been handed over before it pulses pre_all. It exercises the second with a phase that drives cmd_ready with arbitrary values, and in that phase the gap checks only require the minimum gap. Request inputs are held steady from the moment they are raised until the cycle that accepts them.

// File: rtl/brt_pkg.sv
package brt_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_ACT   = 2'd2,
    OP_PRE   = 2'd3
  } cmd_op_e;

  typedef enum logic [1:0] {
    LK_HIT      = 2'd0,
    LK_EMPTY    = 2'd1,
    LK_CONFLICT = 2'd2
  } lk_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_GAP_A = 3'd2,
    ST_ACT   = 3'd3,
    ST_GAP_C = 3'd4,
    ST_COL   = 3'd5
  } seq_state_e;
endpackage

// File: rtl/brt_slot_table.sv
module brt_slot_table #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [BANK_W-1:0]                   lk_bank,
  input  logic [ROW_W-1:0]                    lk_row,
  output brt_pkg::lk_kind_e                   lk_kind,
  output logic [BANK_W-1:0]                   lk_open_bank,
  input  logic                                act_we,
  input  logic                                pre_we,
  input  logic                                clr_all,
  input  logic [BANK_W-1:0]                   upd_bank,
  input  logic [ROW_W-1:0]                    upd_row,
  output logic [(1<<(BANK_W-1))-1:0]          vld_o,
  output logic [(1<<(BANK_W-1))-1:0][BANK_W-1:0] bank_o,
  output logic [(1<<(BANK_W-1))-1:0][ROW_W-1:0]  row_o
);
  localparam int IDX_W = BANK_W - 1;
  localparam int NSLOT = 1 << IDX_W;

  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] upd_idx;

  assign lk_idx  = lk_bank[IDX_W-1:0];
  assign upd_idx = upd_bank[IDX_W-1:0];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic              vld_q, vld_d;
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;
    logic              sel;
    logic              ld;

    assign sel = (upd_idx == IDX_W'(s));
    assign ld  = act_we && sel;

    always_comb begin
      vld_d = vld_q;
      if (clr_all)           vld_d = 1'b0;
      else if (ld)           vld_d = 1'b1;
      else if (pre_we && sel) vld_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= vld_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_q <= '0;
        row_q  <= '0;
      end else if (ld) begin
        bank_q <= upd_bank;
        row_q  <= upd_row;
      end
    end

    assign vld_o[s]  = vld_q;
    assign bank_o[s] = bank_q;
    assign row_o[s]  = row_q;
  end

  always_comb begin
    lk_open_bank = bank_o[lk_idx];
    if (!vld_o[lk_idx])
      lk_kind = brt_pkg::LK_EMPTY;
    else if (bank_o[lk_idx] == lk_bank && row_o[lk_idx] == lk_row)
      lk_kind = brt_pkg::LK_HIT;
    else
      lk_kind = brt_pkg::LK_CONFLICT;
  end

  // An activate may only land in an empty slot: at most one open bank per slot pair.
  assert_act_to_empty_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    act_we |-> !vld_o[upd_idx]);

  // A precharge always closes the bank that the slot says is open.
  assert_pre_closes_open_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pre_we |-> (vld_o[upd_idx] && bank_o[upd_idx] == upd_bank));

  assert_single_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_we && pre_we));

  // After an activate the slot reports that bank and row as open.
  assert_act_records_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_we && !clr_all) |=> (vld_o[$past(upd_idx)] && bank_o[$past(upd_idx)] == $past(upd_bank)
                              && row_o[$past(upd_idx)] == $past(upd_row)));

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (vld_o == '0));
endmodule

// File: rtl/brt_seq.sv
module brt_seq #(
  parameter int BANK_W  = 3,
  parameter int ROW_W   = 14,
  parameter int MIN_GAP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic              req_write,
  input  logic              pre_all,
  input  brt_pkg::lk_kind_e lk_kind,
  input  logic [BANK_W-1:0] lk_open_bank,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output brt_pkg::cmd_op_e  cmd_op,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic              act_we,
  output logic              pre_we,
  output logic              clr_all,
  output logic [BANK_W-1:0] upd_bank,
  output logic [ROW_W-1:0]  upd_row
);
  import brt_pkg::*;

  localparam int GAP_W = (MIN_GAP < 2) ? 1 : $clog2(MIN_GAP);
  localparam logic [GAP_W-1:0] GAP_LOAD = (MIN_GAP > 0) ? GAP_W'(MIN_GAP - 1) : '0;
  localparam int SW = $clog2(MIN_GAP + 2);

  seq_state_e        state_q, state_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [BANK_W-1:0] pre_bank_q, pre_bank_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic              wr_q, wr_d;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic              accept;
  logic              fire;

  assign req_ready = (state_q == ST_IDLE) && !pre_all;
  assign accept    = req_valid && req_ready;
  assign clr_all   = pre_all && (state_q == ST_IDLE);
  assign cmd_valid = (state_q == ST_PRE) || (state_q == ST_ACT) || (state_q == ST_COL);
  assign fire      = cmd_valid && cmd_ready;

  always_comb begin
    case (state_q)
      ST_PRE:  cmd_op = OP_PRE;
      ST_ACT:  cmd_op = OP_ACT;
      default: cmd_op = wr_q ? OP_WRITE : OP_READ;
    endcase
    cmd_bank = (state_q == ST_PRE) ? pre_bank_q : bank_q;
    cmd_row  = row_q;
  end

  assign pre_we   = (state_q == ST_PRE) && cmd_ready;
  assign act_we   = (state_q == ST_ACT) && cmd_ready;
  assign upd_bank = cmd_bank;
  assign upd_row  = row_q;

  always_comb begin
    state_d    = state_q;
    bank_d     = bank_q;
    pre_bank_d = pre_bank_q;
    row_d      = row_q;
    wr_d       = wr_q;
    gap_d      = gap_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          bank_d     = req_bank;
          row_d      = req_row;
          wr_d       = req_write;
          pre_bank_d = lk_open_bank;
          case (lk_kind)
            LK_HIT:   state_d = ST_COL;
            LK_EMPTY: state_d = ST_ACT;
            default:  state_d = ST_PRE;
          endcase
        end
      end
      ST_PRE: begin
        if (cmd_ready) begin
          gap_d   = GAP_LOAD;
          state_d = (MIN_GAP == 0) ? ST_ACT : ST_GAP_A;
        end
      end
      ST_GAP_A: begin
        if (gap_q == '0) state_d = ST_ACT;
        else             gap_d   = gap_q - 1'b1;
      end
      ST_ACT: begin
        if (cmd_ready) begin
          gap_d   = GAP_LOAD;
          state_d = (MIN_GAP == 0) ? ST_COL : ST_GAP_C;
        end
      end
      ST_GAP_C: begin
        if (gap_q == '0) state_d = ST_COL;
        else             gap_d   = gap_q - 1'b1;
      end
      ST_COL: begin
        if (cmd_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      bank_q     <= '0;
      pre_bank_q <= '0;
      row_q      <= '0;
      wr_q       <= 1'b0;
      gap_q      <= '0;
    end else begin
      state_q    <= state_d;
      bank_q     <= bank_d;
      pre_bank_q <= pre_bank_d;
      row_q      <= row_d;
      wr_q       <= wr_d;
      gap_q      <= gap_d;
    end
  end

  // Checker state: idle cycles since the last handshake and the kind of that handshake.
  logic [SW-1:0] since_q;
  cmd_op_e       last_op_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q   <= '0;
      last_op_q <= OP_READ;
    end else if (fire) begin
      since_q   <= '0;
      last_op_q <= cmd_op;
    end else if (since_q < SW'(MIN_GAP)) begin
      since_q <= since_q + 1'b1;
    end
  end

  assert_gap_pre_act_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_op == OP_ACT && last_op_q == OP_PRE) |-> (since_q >= SW'(MIN_GAP)));

  assert_gap_act_col_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (cmd_op == OP_READ || cmd_op == OP_WRITE) && last_op_q == OP_ACT)
      |-> (since_q >= SW'(MIN_GAP)));

  assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_bank)
                                   && $stable(cmd_row)));

  assert_one_at_a_time_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && cmd_valid));

  assert_first_cmd_next_R11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> cmd_valid);

  assert_col_bank_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (cmd_bank == $past(req_bank) || cmd_op == OP_PRE));
endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker #(
  parameter int BANK_W  = 3,
  parameter int ROW_W   = 14,
  parameter int MIN_GAP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic              req_write,
  input  logic              pre_all,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row
);
  localparam int IDX_W = BANK_W - 1;
  localparam int NSLOT = 1 << IDX_W;

  brt_pkg::lk_kind_e            lk_kind;
  brt_pkg::cmd_op_e             op_e;
  logic [BANK_W-1:0]            lk_open_bank;
  logic                         act_we, pre_we, clr_all;
  logic [BANK_W-1:0]            upd_bank;
  logic [ROW_W-1:0]             upd_row;
  logic [NSLOT-1:0]             slot_vld;
  logic [NSLOT-1:0][BANK_W-1:0] slot_bank;
  logic [NSLOT-1:0][ROW_W-1:0]  slot_row;

  brt_slot_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) table_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_bank      (req_bank),
    .lk_row       (req_row),
    .lk_kind      (lk_kind),
    .lk_open_bank (lk_open_bank),
    .act_we       (act_we),
    .pre_we       (pre_we),
    .clr_all      (clr_all),
    .upd_bank     (upd_bank),
    .upd_row      (upd_row),
    .vld_o        (slot_vld),
    .bank_o       (slot_bank),
    .row_o        (slot_row)
  );

  brt_seq #(.BANK_W(BANK_W), .ROW_W(ROW_W), .MIN_GAP(MIN_GAP)) seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_bank     (req_bank),
    .req_row      (req_row),
    .req_write    (req_write),
    .pre_all      (pre_all),
    .lk_kind      (lk_kind),
    .lk_open_bank (lk_open_bank),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_op       (op_e),
    .cmd_bank     (cmd_bank),
    .cmd_row      (cmd_row),
    .act_we       (act_we),
    .pre_we       (pre_we),
    .clr_all      (clr_all),
    .upd_bank     (upd_bank),
    .upd_row      (upd_row)
  );

  assign cmd_op = op_e;

  logic [IDX_W-1:0] cmd_idx;
  assign cmd_idx = cmd_bank[IDX_W-1:0];

  // A column command only goes to a bank whose row is open in the table.
  assert_col_on_open_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op[1] == 1'b0)
      |-> (slot_vld[cmd_idx] && slot_bank[cmd_idx] == cmd_bank && slot_row[cmd_idx] == cmd_row));

  assert_ready_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!cmd_valid));
endmodule

// File: tb/bank_row_tracker_tb_top.sv
module bank_row_tracker_tb_top;
  localparam int BANK_W  = 3;
  localparam int ROW_W   = 2;
  localparam int MIN_GAP = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_ready, req_write, pre_all;
  logic [BANK_W-1:0] req_bank;
  logic [ROW_W-1:0]  req_row;
  logic              cmd_valid, cmd_ready;
  logic [1:0]        cmd_op;
  logic [BANK_W-1:0] cmd_bank;
  logic [ROW_W-1:0]  cmd_row;

  bank_row_tracker #(.BANK_W(BANK_W), .ROW_W(ROW_W), .MIN_GAP(MIN_GAP)) dut_i (
    .clk, .rst_n, .req_valid, .req_ready, .req_bank, .req_row, .req_write,
    .pre_all, .cmd_valid, .cmd_ready, .cmd_op, .cmd_bank, .cmd_row
  );

  always #2 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  longint cyc = 0;
  longint last_fire = 0;
  bit    bp_mode = 1'b0;
  bit    done = 1'b0;

  int    q_op[$];
  int    q_bank[$];
  int    q_row[$];
  int    q_gap[$];
  string q_tag[$];

  bit               m_vld[4];
  logic [2:0]       m_bank[4];
  logic [ROW_W-1:0] m_row[4];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int op, input int b, input int r, input int gap, input string tag);
    q_op.push_back(op); q_bank.push_back(b); q_row.push_back(r);
    q_gap.push_back(gap); q_tag.push_back(tag);
  endtask

  // Command monitor: samples between edges; a handshake is visible before its edge.
  always @(negedge clk) begin
    cyc++;
    if (rst_n && cmd_valid && cmd_ready) begin
      if (q_op.size() == 0) begin
        chk(1'b0, "R8 unexpected command", cmd_op, -1);
      end else begin
        int op, b, r, g;
        string t;
        op = q_op.pop_front(); b = q_bank.pop_front(); r = q_row.pop_front();
        g = q_gap.pop_front(); t = q_tag.pop_front();
        chk(cmd_op == op[1:0], {t, " op"}, cmd_op, op);
        chk(cmd_bank == b[2:0], {t, " bank"}, cmd_bank, b);
        if (op != 3) chk(cmd_row == r[ROW_W-1:0], {t, " row"}, cmd_row, r);
        if (g >= 0) begin
          if (bp_mode) chk((cyc - last_fire - 1) >= g, "R7 min gap", cyc - last_fire - 1, g);
          else         chk((cyc - last_fire - 1) == g, "R7 exact gap", cyc - last_fire - 1, g);
        end
      end
      last_fire = cyc;
    end
  end

  task automatic send(input logic [2:0] b, input logic [ROW_W-1:0] r, input logic wr, input string ph);
    int idx;
    int col;
    bit ok;
    idx = int'(b[1:0]);
    col = wr ? 1 : 0;
    if (m_vld[idx] && m_bank[idx] == b && m_row[idx] == r) begin
      push(col, b, r, -1, {ph, "/R2 hit R10"});
    end else if (!m_vld[idx]) begin
      push(2, b, r, -1, {ph, "/R3 act"});
      push(col, b, r, MIN_GAP, {ph, "/R3 col R10"});
    end else begin
      string k;
      k = (m_bank[idx] == b) ? "/R4" : "/R5 partner";
      push(3, m_bank[idx], 0, -1, {ph, k, " pre"});
      push(2, b, r, MIN_GAP, {ph, k, " act"});
      push(col, b, r, MIN_GAP, {ph, k, " col"});
    end
    m_vld[idx] = 1'b1; m_bank[idx] = b; m_row[idx] = r;

    @(posedge clk); #1;
    req_valid = 1'b1; req_bank = b; req_row = r; req_write = wr;
    ok = 1'b0;
    while (!ok) begin
      @(negedge clk); ok = req_ready;
      @(posedge clk);
    end
    #1 req_valid = 1'b0;
    @(negedge clk);
    chk(cmd_valid === 1'b1, "R11 first command next cycle", cmd_valid, 1);
    chk(req_ready === 1'b0, "R8 busy after accept", req_ready, 0);
  endtask

  task automatic drain();
    while (q_op.size() != 0) @(negedge clk);
  endtask

  task automatic close_all();
    drain();
    @(posedge clk); #1;
    pre_all = 1'b1; req_valid = 1'b1; req_bank = '0; req_row = '0; req_write = 1'b0;
    @(negedge clk);
    chk(req_ready === 1'b0, "R9 no accept with pre_all", req_ready, 0);
    @(posedge clk); #1;
    pre_all = 1'b0; req_valid = 1'b0;
    for (int i = 0; i < 4; i++) m_vld[i] = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    cmd_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      cmd_ready = bp_mode ? 1'($urandom % 2) : 1'b1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", cyc, 0);
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_bank = '0; req_row = '0; req_write = 1'b0; pre_all = 1'b0;
    for (int i = 0; i < 4; i++) begin m_vld[i] = 1'b0; m_bank[i] = '0; m_row[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 req_ready after reset", req_ready, 1);
    chk(cmd_valid === 1'b0, "R1 cmd_valid after reset", cmd_valid, 0);

    // R1: first access of every slot activates.
    for (int b = 0; b < 4; b++) send(3'(b), 2'(b), 1'b0, "R1");
    // R6: all four slots stay open together, so each is a hit.
    for (int b = 0; b < 4; b++) send(3'(b), 2'(b), 1'b1, "R6");

    // Sweep every bank, row and direction.
    for (int b = 0; b < 8; b++)
      for (int r = 0; r < 4; r++)
        for (int w = 0; w < 2; w++) send(3'(b), 2'(r), 1'(w), "sweep");

    // R5: alternate partner banks in every slot.
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 6; k++) send(3'(s + 4 * (k % 2)), 2'(k % 3), 1'(k % 2), "R5 alternate");

    // R9: after closing all, previously open rows need a fresh activate.
    close_all();
    for (int b = 4; b < 8; b++) send(3'(b), 2'(b % 4), 1'b0, "R9");
    close_all();
    send(3'd2, 2'd1, 1'b1, "R9");

    // Back-pressure phase with arbitrary accesses.
    drain();
    bp_mode = 1'b1;
    for (int n = 0; n < 300; n++) begin
      send(3'($urandom % 8), 2'($urandom % 4), 1'($urandom % 2), "R8 backpressure");
      if (n % 97 == 96) close_all();
    end
    drain();
    repeat (4) @(negedge clk);
    chk(q_op.size() == 0, "R8 all commands issued", q_op.size(), 0);
    done = 1'b1;
    summary();
  end
endmodule